// File: doc/BRIEF.md
# Universal Canonical ALU

A combinational n-bit arithmetic and logic unit that evaluates exactly one of 27 canonical functions, chosen by a 5-bit function code. The set is five arithmetic operations (add, subtract, reverse subtract, increment, decrement), all sixteen Boolean functions of two variables applied bit by bit, and six signed comparisons. Two n-bit operands and a carry-in feed the block. It returns an n-bit result, a carry-out, an overflow flag and a separate single-bit comparison flag.

The logic functions are not built from individual gates. Each result bit ANDs the four minterms of its operand bit pair with a 4-bit enable taken from the function code, then ORs the terms, so a single structure covers all sixteen functions. The block serves as a reference datapath element against which narrower library ALUs can be matched. Any function it lacks can then be realised from one it has, plus glue logic.

Top module: `canon_alu`

## Requirements
- R1: Code 0 (add) gives result = (A + B + Cin) mod 2^n, and carry-out is bit n of that sum.
- R2: Code 1 (subtract) gives A + ~B + Cin. With Cin = 1 this is A - B, and carry-out is 1 when no borrow occurs.
- R3: Code 2 (reverse subtract) gives B + ~A + Cin. With Cin = 1 this is B - A.
- R4: Code 3 (increment) gives A + 1, and code 4 (decrement) gives A + all-ones. Both ignore B and Cin. Decrement's carry-out is 1 unless A is zero.
- R5: For codes 0 to 4, overflow is 1 exactly when both adder operands have the same sign and the sum's sign differs. This is the same as the true two's complement result falling outside the n-bit range.
- R6: For codes 5 to 20 the enable e = code - 5. Result bit i equals e[2*A[i] + B[i]]. So e bit 0 enables ~A&~B, bit 1 enables ~A&B, bit 2 enables A&~B and bit 3 enables A&B. For example, code 13 is AND, code 11 is XOR and code 19 is OR.
- R7: Codes 21 to 26 give EQ, NEQ, GT, GEQ, LT and LEQ of A against B, both taken as two's complement. The outcome appears on the comparison flag.
- R8: The comparison flag is 0 for every code outside 21 to 26. The n-bit result is 0 for codes 21 to 26.
- R9: Carry-out and overflow are 0 for every code from 5 to 31.
- R10: Codes 27 to 31 drive every output to 0.
- R11: For logic and comparison codes, Cin has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| op_a_i | input | WIDTH | First operand A |
| op_b_i | input | WIDTH | Second operand B |
| carry_i | input | 1 | Carry-in for add and the two subtracts |
| func_i | input | 5 | Function code 0 to 31 |
| result_o | output | WIDTH | n-bit result of arithmetic or logic codes |
| carry_o | output | 1 | Carry-out of arithmetic codes |
| ovf_o | output | 1 | Signed overflow of arithmetic codes |
| cmp_o | output | 1 | Outcome of comparison codes |

## Verification
The adder path and the compare subtractor both run on every code. The concern is therefore that an arithmetic carry or overflow, or a comparison outcome, appears during a function of another class. To provoke this, the bench sweeps every code against every operand pair and both carry-in values on a 4-bit build. This includes the corners 0, -1, the most negative and the most positive value, where borrows and sign flips are densest. Each output is judged for every vector: the outputs that belong to the active class must match the arithmetic expected value, and the outputs of the other classes must hold 0.

// File: rtl/canon_alu_pkg.sv
package canon_alu_pkg;

  localparam int FUNC_W      = 5;
  localparam int N_ARITH     = 5;
  localparam int N_LOGIC     = 16;
  localparam int N_CMP       = 6;
  localparam int LOGIC_BASE  = N_ARITH;
  localparam int CMP_BASE    = LOGIC_BASE + N_LOGIC;
  localparam int N_FUNCS     = CMP_BASE + N_CMP;

  typedef enum logic [1:0] {
    CLS_ARITH = 2'd0,
    CLS_LOGIC = 2'd1,
    CLS_CMP   = 2'd2,
    CLS_NONE  = 2'd3
  } fn_class_e;

  typedef enum logic [2:0] {
    AR_ADD  = 3'd0,
    AR_SUB  = 3'd1,
    AR_RSUB = 3'd2,
    AR_INC  = 3'd3,
    AR_DEC  = 3'd4
  } arith_op_e;

  typedef enum logic [2:0] {
    CM_EQ  = 3'd0,
    CM_NEQ = 3'd1,
    CM_GT  = 3'd2,
    CM_GEQ = 3'd3,
    CM_LT  = 3'd4,
    CM_LEQ = 3'd5
  } cmp_op_e;

  typedef struct packed {
    fn_class_e  cls;
    arith_op_e  aop;
    logic [3:0] lmask;
    cmp_op_e    cop;
  } fn_decode_t;

endpackage

// File: rtl/canon_alu_decode.sv
module canon_alu_decode
  import canon_alu_pkg::*;
(
  input  logic [FUNC_W-1:0] func_i,
  output fn_decode_t        dec_o
);

  logic [FUNC_W-1:0] logic_off;
  logic [FUNC_W-1:0] cmp_off;

  assign logic_off = func_i - FUNC_W'(LOGIC_BASE);
  assign cmp_off   = func_i - FUNC_W'(CMP_BASE);

  always_comb begin
    dec_o.cls   = CLS_NONE;
    dec_o.aop   = AR_ADD;
    dec_o.lmask = '0;
    dec_o.cop   = CM_EQ;
    if (int'(func_i) < LOGIC_BASE) begin
      dec_o.cls = CLS_ARITH;
      dec_o.aop = arith_op_e'(func_i[2:0]);
    end else if (int'(func_i) < CMP_BASE) begin
      dec_o.cls   = CLS_LOGIC;
      dec_o.lmask = logic_off[3:0];
    end else if (int'(func_i) < N_FUNCS) begin
      dec_o.cls = CLS_CMP;
      dec_o.cop = cmp_op_e'(cmp_off[2:0]);
    end
  end

  always_comb begin
    if (dec_o.cls == CLS_LOGIC) begin
      AST_LOGIC_MASK_RANGE: assert (int'(dec_o.lmask) + LOGIC_BASE == int'(func_i))
        else $error("logic enable does not track code"); // R6
    end
  end

endmodule

// File: rtl/canon_alu_arith.sv
module canon_alu_arith
  import canon_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  arith_op_e          op_i,
  input  logic [WIDTH-1:0]   a_i,
  input  logic [WIDTH-1:0]   b_i,
  input  logic               cin_i,
  output logic [WIDTH-1:0]   sum_o,
  output logic               cout_o,
  output logic               ovf_o
);

  localparam int MSB = WIDTH - 1;

  // Ripple sum returning {carry into msb, carry out, sum}.
  function automatic logic [WIDTH+1:0] ripple_add(
    input logic [WIDTH-1:0] x,
    input logic [WIDTH-1:0] y,
    input logic             c0
  );
    logic [WIDTH:0]   c;
    logic [WIDTH-1:0] s;
    c[0] = c0;
    for (int i = 0; i < WIDTH; i++) begin
      s[i]   = x[i] ^ y[i] ^ c[i];
      c[i+1] = (x[i] & y[i]) | (c[i] & (x[i] ^ y[i]));
    end
    return {c[MSB], c[WIDTH], s};
  endfunction

  function automatic logic sign_overflow(
    input logic xs,
    input logic ys,
    input logic ss
  );
    return (xs == ys) && (ss != xs);
  endfunction

  logic [WIDTH-1:0] add_x;
  logic [WIDTH-1:0] add_y;
  logic             add_c0;
  logic [WIDTH+1:0] add_res;
  logic             carry_into_msb;

  always_comb begin
    add_x  = a_i;
    add_y  = b_i;
    add_c0 = cin_i;
    unique case (op_i)
      AR_ADD:  begin add_x = a_i; add_y = b_i;  add_c0 = cin_i; end
      AR_SUB:  begin add_x = a_i; add_y = ~b_i; add_c0 = cin_i; end
      AR_RSUB: begin add_x = b_i; add_y = ~a_i; add_c0 = cin_i; end
      AR_INC:  begin add_x = a_i; add_y = '0;   add_c0 = 1'b1;  end
      AR_DEC:  begin add_x = a_i; add_y = '1;   add_c0 = 1'b0;  end
      default: begin add_x = a_i; add_y = b_i;  add_c0 = cin_i; end
    endcase
  end

  assign add_res        = ripple_add(add_x, add_y, add_c0);
  assign sum_o          = add_res[WIDTH-1:0];
  assign cout_o         = add_res[WIDTH];
  assign carry_into_msb = add_res[WIDTH+1];
  assign ovf_o          = sign_overflow(add_x[MSB], add_y[MSB], sum_o[MSB]);

  always_comb begin
    AST_OVF_MATCHES_CARRIES: assert (ovf_o == (cout_o ^ carry_into_msb))
      else $error("overflow disagrees with carry pair"); // R5
    if (op_i == AR_DEC) begin
      AST_DEC_CARRY: assert (cout_o == (a_i != '0))
        else $error("decrement carry wrong"); // R4
    end
  end

endmodule

// File: rtl/canon_alu_logic.sv
module canon_alu_logic #(
  parameter int WIDTH = 8
) (
  input  logic [3:0]       mask_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic [WIDTH-1:0] y_o
);

  localparam int N_MINTERMS = 4;

  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic [N_MINTERMS-1:0] minterm;
    assign minterm[0] = ~a_i[i] & ~b_i[i];
    assign minterm[1] = ~a_i[i] &  b_i[i];
    assign minterm[2] =  a_i[i] & ~b_i[i];
    assign minterm[3] =  a_i[i] &  b_i[i];
    assign y_o[i]     = |(minterm & mask_i);
  end

  always_comb begin
    if (mask_i == 4'b1000) begin
      AST_AND_FORM: assert (y_o == (a_i & b_i)) else $error("AND form wrong"); // R6
    end
    if (mask_i == 4'b0110) begin
      AST_XOR_FORM: assert (y_o == (a_i ^ b_i)) else $error("XOR form wrong"); // R6
    end
    if (mask_i == 4'b1110) begin
      AST_OR_FORM: assert (y_o == (a_i | b_i)) else $error("OR form wrong"); // R6
    end
  end

endmodule

// File: rtl/canon_alu_cmp.sv
module canon_alu_cmp
  import canon_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  cmp_op_e          op_i,
  input  logic [WIDTH-1:0] a_i,
  input  logic [WIDTH-1:0] b_i,
  output logic             flag_o
);

  localparam int MSB = WIDTH - 1;

  logic [WIDTH:0] diff;
  logic           is_eq;
  logic           is_lt;
  logic           is_gt;

  assign diff  = {a_i[MSB], a_i} - {b_i[MSB], b_i};
  assign is_eq = ~|(a_i ^ b_i);
  assign is_lt = diff[WIDTH];
  assign is_gt = ~diff[WIDTH] & (|diff);

  always_comb begin
    unique case (op_i)
      CM_EQ:   flag_o = is_eq;
      CM_NEQ:  flag_o = ~is_eq;
      CM_GT:   flag_o = is_gt;
      CM_GEQ:  flag_o = ~is_lt;
      CM_LT:   flag_o = is_lt;
      CM_LEQ:  flag_o = ~is_gt;
      default: flag_o = 1'b0;
    endcase
  end

  always_comb begin
    AST_CMP_TRICHOTOMY: assert ($onehot({is_eq, is_lt, is_gt}))
      else $error("equal, less and greater not exclusive"); // R7
  end

endmodule

// File: rtl/canon_alu.sv
module canon_alu
  import canon_alu_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic [WIDTH-1:0]  op_a_i,
  input  logic [WIDTH-1:0]  op_b_i,
  input  logic              carry_i,
  input  logic [FUNC_W-1:0] func_i,
  output logic [WIDTH-1:0]  result_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              cmp_o
);

  fn_decode_t       dec;
  logic             sel_arith;
  logic             sel_logic;
  logic             sel_cmp;
  logic [WIDTH-1:0] arith_sum;
  logic             arith_cout;
  logic             arith_ovf;
  logic [WIDTH-1:0] logic_y;
  logic             cmp_flag;

  canon_alu_decode u_decode (
    .func_i (func_i),
    .dec_o  (dec)
  );

  canon_alu_arith #(.WIDTH(WIDTH)) u_arith (
    .op_i   (dec.aop),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .cin_i  (carry_i),
    .sum_o  (arith_sum),
    .cout_o (arith_cout),
    .ovf_o  (arith_ovf)
  );

  canon_alu_logic #(.WIDTH(WIDTH)) u_logic (
    .mask_i (dec.lmask),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .y_o    (logic_y)
  );

  canon_alu_cmp #(.WIDTH(WIDTH)) u_cmp (
    .op_i   (dec.cop),
    .a_i    (op_a_i),
    .b_i    (op_b_i),
    .flag_o (cmp_flag)
  );

  assign sel_arith = (dec.cls == CLS_ARITH);
  assign sel_logic = (dec.cls == CLS_LOGIC);
  assign sel_cmp   = (dec.cls == CLS_CMP);

  always_comb begin
    result_o = '0;
    if (sel_arith)      result_o = arith_sum;
    else if (sel_logic) result_o = logic_y;
  end

  assign carry_o = sel_arith & arith_cout;
  assign ovf_o   = sel_arith & arith_ovf;
  assign cmp_o   = sel_cmp & cmp_flag;

  always_comb begin
    AST_ONE_CLASS: assert ($onehot0({sel_arith, sel_logic, sel_cmp}))
      else $error("more than one function class active"); // R10
    AST_CMP_RESULT_SPLIT: assert (!(cmp_o && (result_o != '0)))
      else $error("comparison flag alongside nonzero result"); // R8
    if (int'(func_i) >= LOGIC_BASE) begin
      AST_NO_FLAGS_OUTSIDE_ARITH: assert (!carry_o && !ovf_o)
        else $error("carry or overflow outside arithmetic"); // R9
    end
    if (int'(func_i) >= N_FUNCS) begin
      AST_UNUSED_CODE_QUIET: assert ((result_o == '0) && !cmp_o)
        else $error("unused code drives an output"); // R10
    end
  end

endmodule

// File: tb/canon_alu_tb.sv
module canon_alu_tb;

  localparam int W    = 4;
  localparam int M    = 1 << W;
  localparam int HALF = M / 2;

  logic         clk = 1'b0;
  logic [W-1:0] a = '0;
  logic [W-1:0] b = '0;
  logic         cin = 1'b0;
  logic [4:0]   code = '0;
  logic [W-1:0] res;
  logic         cout;
  logic         ovf;
  logic         cmp;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  canon_alu #(.WIDTH(W)) u_dut (
    .op_a_i   (a),
    .op_b_i   (b),
    .carry_i  (cin),
    .func_i   (code),
    .result_o (res),
    .carry_o  (cout),
    .ovf_o    (ovf),
    .cmp_o    (cmp)
  );

  function automatic int to_signed(input int v);
    return (v >= HALF) ? v - M : v;
  endfunction

  task automatic check(input string req, input string what, input int act, input int exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s code=%0d a=%0d b=%0d cin=%0d actual=%0d expected=%0d",
               req, what, code, a, b, cin, act, exp);
    end
  endtask

  task automatic run_vector(input int c, input int av, input int bv, input int ci);
    int u;
    int s;
    int sa;
    int sb;
    int er;
    int ec;
    int eo;
    int ek;
    string rq;
    string rq_flags;
    string rq_cmp;
    @(posedge clk);
    code = 5'(c);
    a    = W'(av);
    b    = W'(bv);
    cin  = 1'(ci);
    #2;
    sa = to_signed(av);
    sb = to_signed(bv);
    er = 0; ec = 0; eo = 0; ek = 0;
    rq_flags = "R9";
    rq_cmp   = "R8";
    if (c < 5) begin
      case (c)
        0: begin u = av + bv + ci;           s = sa + sb + ci;     rq = "R1"; end
        1: begin u = av + (M - 1 - bv) + ci; s = sa - sb - 1 + ci; rq = "R2"; end
        2: begin u = bv + (M - 1 - av) + ci; s = sb - sa - 1 + ci; rq = "R3"; end
        3: begin u = av + 1;                 s = sa + 1;           rq = "R4"; end
        default: begin u = av + M - 1;       s = sa - 1;           rq = "R4"; end
      endcase
      er = u % M;
      ec = u / M;
      eo = (s >= HALF || s < -HALF) ? 1 : 0;
      rq_flags = rq;
    end else if (c < 21) begin
      for (int i = 0; i < W; i++) begin
        int idx;
        idx = ((av >> i) & 1) * 2 + ((bv >> i) & 1);
        er = er | ((((c - 5) >> idx) & 1) << i);
      end
      rq = (ci != 0) ? "R6 R11" : "R6";
      rq_flags = (ci != 0) ? "R9 R11" : "R9";
    end else if (c < 27) begin
      case (c)
        21: ek = (sa == sb);
        22: ek = (sa != sb);
        23: ek = (sa >  sb);
        24: ek = (sa >= sb);
        25: ek = (sa <  sb);
        default: ek = (sa <= sb);
      endcase
      rq = "R8";
      rq_cmp = (ci != 0) ? "R7 R11" : "R7";
    end else begin
      rq = "R10";
      rq_cmp = "R8 R10";
      rq_flags = "R9 R10";
    end
    check(rq, "result", int'(res), er);
    check(rq_flags, "carry", int'(cout), ec);
    check((c < 5) ? "R5" : rq_flags, "overflow", int'(ovf), eo);
    check(rq_cmp, "cmp", int'(cmp), ek);
  endtask

  initial begin
    // Quiet state with all inputs zero and code 0.
    #1;
    check("R1", "idle result", int'(res), 0);
    check("R1", "idle carry", int'(cout), 0);
    // Named spot checks at the signed corners.
    run_vector(0, HALF - 1, 1, 0);
    check("R5", "max+1 overflow", int'(ovf), 1);
    run_vector(4, HALF, 0, 1);
    check("R4", "dec min result", int'(res), HALF - 1);
    run_vector(3, M - 1, 5, 1);
    check("R4", "inc -1 result", int'(res), 0);
    check("R4", "inc -1 carry", int'(cout), 1);
    // Exhaustive sweep over every code, operand pair and carry-in.
    for (int c = 0; c < 32; c++)
      for (int av = 0; av < M; av++)
        for (int bv = 0; bv < M; bv++)
          for (int ci = 0; ci < 2; ci++)
            run_vector(c, av, bv, ci);
    done = 1'b1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

endmodule